// File: doc/BRIEF.md
# Masked Integer Lane with Overflow Trapping

This block is one integer lane of a vector execution unit. Each valid issue carries an operation (add, subtract, multiply, multiply-add or shift left), up to three source operands, an optional explicit fallback operand, a per-element mask byte and an element size of 8, 16, 32 or 64 bits. One clock later the lane presents the destination element, zero-extended from the selected size, together with a trap flag and a two-bit cause.

The mask byte controls three things. Its enable bit decides whether the element is computed or replaced by a fallback. The two trap-enable bits arm unsigned and signed overflow detection. Overflow is judged on the exact mathematical result at the selected size. Products are formed at full double width, and multiply-add is judged once, on the fused sum, so an intermediate product that would overflow on its own is not reported. A masked-off element never keeps stale contents. It takes the explicit fallback when the instruction supplies one, and otherwise it takes the first source.

Top module: `masked_int_lane`

## Requirements
- R1: Results appear exactly one clock after an issue. `out_valid` is high in the cycle after `in_valid` is high, and low in the cycle after `in_valid` is low. Cycles without an issue show no trap. After reset, `out_valid`, `dest`, `trap_valid` and `trap_cause` are all zero.
- R2: The opcode encoding is 0 add (a+b), 1 subtract (a-b), 2 multiply (a*b), 3 multiply-add (a*b+c) and 4 shift left (a shifted by b). The destination is the low N bits of the exact result.
- R3: The size code is 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Source operands are read from their low N bits only, and destination bits at and above N are always zero.
- R4: When mask bit 0 is clear, the element is masked off and `dest` receives the fallback value cut to N bits. The fallback is `fb_val` when `fb_present` is high, and `src_a` otherwise.
- R5: A masked-off element never raises a trap, whatever its trap-enable bits are.
- R6: With mask bit 6 set, an exact result outside the range 0 to 2^N-1 sets `trap_cause[0]`. With bit 6 clear, that cause bit stays low.
- R7: With mask bit 7 set, an exact result outside the range -2^(N-1) to 2^(N-1)-1 (operands read as signed) sets `trap_cause[1]`. Both cause bits may be set at once. `trap_valid` is the OR of the two cause bits.
- R8: Multiply overflow is judged on the full double-width product. For example, -1 times -1 at 64 bits is an unsigned overflow but not a signed one.
- R9: For multiply-add, overflow is judged on the complete a*b+c. At 32 bits, 65537*32769 overflows signed, but 65537*32769-100000 does not.
- R10: The shift count is `src_b` modulo N. For shift left, a nonzero bit pushed out of N bits is an unsigned overflow. A value a*2^count that does not fit in the signed range is a signed overflow.
- R11: Overflow is evaluated at the selected size and not at 64 bits.
- R12: Opcodes 5 to 7 produce a zero destination for an enabled element and never trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe |
| op | input | 3 | Operation code |
| size | input | 2 | Element size code |
| src_a | input | 64 | First source |
| src_b | input | 64 | Second source / shift count |
| src_c | input | 64 | Addend for multiply-add |
| fb_present | input | 1 | Explicit fallback supplied |
| fb_val | input | 64 | Explicit fallback value |
| mask_byte | input | 8 | Bit 0 enable, bit 6 unsigned trap, bit 7 signed trap |
| out_valid | output | 1 | Result valid |
| dest | output | 64 | Destination element |
| trap_valid | output | 1 | Trap raised |
| trap_cause | output | 2 | Bit 0 unsigned, bit 1 signed |

## Verification
The assertions assume that `op`, `size` and `mask_byte` are stable, known values in any cycle where `in_valid` is high. They also assume the lane is never issued while reset is asserted. The bench meets both conditions: it changes inputs only on falling edges, holds `in_valid` low throughout reset, and drops `in_valid` after each single-cycle issue. Because of this, the checks one cycle after an issue always relate to exactly one set of operands.

// File: rtl/lane_pkg.sv
package lane_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_MADD = 3'd3,
        OP_SHL  = 3'd4
    } lane_op_e;

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2,
        SZ64 = 2'd3
    } lane_size_e;

    localparam int unsigned MASK_W    = 8;
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned UTRAP_BIT = 6;
    localparam int unsigned STRAP_BIT = 7;

    // element width in bits for a size code
    function automatic int unsigned elem_bits(input logic [1:0] sz);
        return 32'd8 << sz;
    endfunction
endpackage

// File: rtl/lane_operand.sv
module lane_operand #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned WIDE_W = 2 * DATA_W + 2
) (
    input  logic [1:0]               size,
    input  logic [DATA_W-1:0]        raw,
    output logic signed [WIDE_W-1:0] u_ext,
    output logic signed [WIDE_W-1:0] s_ext
);
    import lane_pkg::*;

    logic [WIDE_W-1:0]        widened;
    logic [WIDE_W-1:0]        pushed;
    int unsigned              drop;

    // move the element's top bit to the wide MSB, then shift back
    always_comb begin
        drop    = WIDE_W - elem_bits(size);
        widened = {{(WIDE_W-DATA_W){1'b0}}, raw};
        pushed  = widened << drop;
        u_ext   = $signed(pushed >> drop);
        s_ext   = $signed(pushed) >>> drop;
    end
endmodule

// File: rtl/lane_arith.sv
module lane_arith #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned WIDE_W = 2 * DATA_W + 2
) (
    input  logic [2:0]               op,
    input  logic [1:0]               size,
    input  logic signed [WIDE_W-1:0] ua,
    input  logic signed [WIDE_W-1:0] ub,
    input  logic signed [WIDE_W-1:0] uc,
    input  logic signed [WIDE_W-1:0] sa,
    input  logic signed [WIDE_W-1:0] sb,
    input  logic signed [WIDE_W-1:0] sc,
    output logic [DATA_W-1:0]        res,
    output logic                     ovf_u,
    output logic                     ovf_s
);
    import lane_pkg::*;

    logic signed [WIDE_W-1:0] exact_u;
    logic signed [WIDE_W-1:0] exact_s;
    logic signed [WIDE_W-1:0] lim_u;
    logic signed [WIDE_W-1:0] lim_s;
    logic [WIDE_W-1:0]        keep;
    logic [6:0]               sh;
    logic                     known_op;
    int unsigned              nbits;

    always_comb begin
        nbits    = elem_bits(size);
        sh       = ub[6:0] & 7'(nbits - 1);
        known_op = 1'b1;
        unique case (op)
            OP_ADD:  begin exact_u = ua + ub;       exact_s = sa + sb;       end
            OP_SUB:  begin exact_u = ua - ub;       exact_s = sa - sb;       end
            OP_MUL:  begin exact_u = ua * ub;       exact_s = sa * sb;       end
            OP_MADD: begin exact_u = ua * ub + uc;  exact_s = sa * sb + sc;  end
            OP_SHL:  begin exact_u = ua <<< sh;     exact_s = sa <<< sh;     end
            default: begin
                exact_u  = '0;
                exact_s  = '0;
                known_op = 1'b0;
            end
        endcase
    end

    // exact range tests at the selected width
    always_comb begin
        lim_u = WIDE_W'(1) << nbits;
        lim_s = WIDE_W'(1) << (nbits - 1);
        keep  = lim_u - 1;
        ovf_u = known_op && (exact_u[WIDE_W-1] || (exact_u >= lim_u));
        ovf_s = known_op && ((exact_s >= lim_s) || (exact_s < -lim_s));
    end

    logic [WIDE_W-1:0] res_w;
    assign res_w = exact_s & keep;
    assign res   = res_w[DATA_W-1:0];
endmodule

// File: rtl/lane_select.sv
module lane_select #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              enable,
    input  logic              fb_present,
    input  logic [DATA_W-1:0] fb_val,
    input  logic [DATA_W-1:0] src_a,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] arith_res,
    output logic [DATA_W-1:0] lane_dest
);
    import lane_pkg::*;

    logic [DATA_W-1:0] size_keep;
    logic [DATA_W-1:0] fallback;

    always_comb begin
        size_keep = {DATA_W{1'b1}} >> (DATA_W - elem_bits(size));
        fallback  = (fb_present ? fb_val : src_a) & size_keep;
        lane_dest = enable ? arith_res : fallback;
    end
endmodule

// File: rtl/masked_int_lane.sv
module masked_int_lane #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_c,
    input  logic              fb_present,
    input  logic [DATA_W-1:0] fb_val,
    input  logic [7:0]        mask_byte,
    output logic              out_valid,
    output logic [DATA_W-1:0] dest,
    output logic              trap_valid,
    output logic [1:0]        trap_cause
);
    import lane_pkg::*;

    localparam int unsigned WIDE_W = 2 * DATA_W + 2;
    localparam int unsigned N_SRC  = 3;

    logic [DATA_W-1:0]        raw   [N_SRC];
    logic signed [WIDE_W-1:0] u_ops [N_SRC];
    logic signed [WIDE_W-1:0] s_ops [N_SRC];

    assign raw[0] = src_a;
    assign raw[1] = src_b;
    assign raw[2] = src_c;

    for (genvar g = 0; g < N_SRC; g++) begin : g_opnd
        lane_operand #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_opnd (
            .size  (size),
            .raw   (raw[g]),
            .u_ext (u_ops[g]),
            .s_ext (s_ops[g])
        );
    end

    logic [DATA_W-1:0] arith_res;
    logic              ovf_u;
    logic              ovf_s;

    lane_arith #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_arith (
        .op    (op),
        .size  (size),
        .ua    (u_ops[0]),
        .ub    (u_ops[1]),
        .uc    (u_ops[2]),
        .sa    (s_ops[0]),
        .sb    (s_ops[1]),
        .sc    (s_ops[2]),
        .res   (arith_res),
        .ovf_u (ovf_u),
        .ovf_s (ovf_s)
    );

    logic              elem_on;
    logic [DATA_W-1:0] lane_dest;

    assign elem_on = mask_byte[EN_BIT];

    lane_select #(.DATA_W(DATA_W)) u_select (
        .enable     (elem_on),
        .fb_present (fb_present),
        .fb_val     (fb_val),
        .src_a      (src_a),
        .size       (size),
        .arith_res  (arith_res),
        .lane_dest  (lane_dest)
    );

    // mask bits between the enable and the trap enables carry no meaning here
    logic mask_unused;
    assign mask_unused = ^mask_byte[UTRAP_BIT-1:EN_BIT+1];

    logic [1:0] nxt_cause;
    logic       nxt_trap;

    always_comb begin
        nxt_cause = '0;
        if (in_valid && elem_on) begin
            nxt_cause[0] = mask_byte[UTRAP_BIT] && ovf_u;
            nxt_cause[1] = mask_byte[STRAP_BIT] && ovf_s;
        end
        nxt_trap = |nxt_cause;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            dest       <= '0;
            trap_valid <= 1'b0;
            trap_cause <= '0;
        end else begin
            out_valid  <= in_valid;
            trap_valid <= nxt_trap;
            trap_cause <= nxt_cause;
            if (in_valid) dest <= lane_dest;
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !trap_valid));
    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_byte[EN_BIT]) |=> !trap_valid);
    // R6
    u_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_byte[UTRAP_BIT]) |=> !trap_cause[0]);
    // R7
    s_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_byte[STRAP_BIT]) |=> !trap_cause[1]);
    // R3
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == SZ8) |=> (dest[DATA_W-1:8] == '0));
    // R12
    reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_byte[EN_BIT] && op > 3'd4) |=> (dest == '0 && !trap_valid));
endmodule

// File: tb/masked_int_lane_bench.sv
`timescale 1ns/1ps
module masked_int_lane_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic [63:0] src_a = '0, src_b = '0, src_c = '0, fb_val = '0;
    logic        fb_present = 1'b0;
    logic [7:0]  mask_byte = '0;
    logic        out_valid, trap_valid;
    logic [63:0] dest;
    logic [1:0]  trap_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    masked_int_lane u_masked_int_lane (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
        .src_a(src_a), .src_b(src_b), .src_c(src_c), .fb_present(fb_present),
        .fb_val(fb_val), .mask_byte(mask_byte), .out_valid(out_valid),
        .dest(dest), .trap_valid(trap_valid), .trap_cause(trap_cause)
    );

    task automatic check(input string req, input logic ov, input logic [63:0] d,
                         input logic [1:0] cause);
        logic tv;
        tv = |cause;
        checks++;
        if (out_valid !== ov || dest !== d || trap_cause !== cause || trap_valid !== tv) begin
            fails++;
            $display("FAIL %s: got valid=%b dest=%h cause=%b trap=%b, expected valid=%b dest=%h cause=%b trap=%b",
                     req, out_valid, dest, trap_cause, trap_valid, ov, d, cause, tv);
        end
    endtask

    task automatic run(input string req, input logic [2:0] o, input logic [1:0] sz,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                       input logic fbp, input logic [63:0] fb, input logic [7:0] m,
                       input logic [63:0] exp_d, input logic [1:0] exp_c);
        @(negedge clk);
        in_valid = 1'b1; op = o; size = sz; src_a = a; src_b = b; src_c = c;
        fb_present = fbp; fb_val = fb; mask_byte = m;
        @(negedge clk);
        check(req, 1'b1, exp_d, exp_c);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset", 1'b0, 64'h0, 2'b00);
    endtask

    task automatic t_basic;
        run("R2 add", 3'd0, 2'd3, 64'd5, 64'd7, 64'd0, 1'b0, 64'd0, 8'hC1, 64'd12, 2'b00);
        run("R2 sub", 3'd1, 2'd3, 64'd10, 64'd3, 64'd0, 1'b0, 64'd0, 8'hC1, 64'd7, 2'b00);
    endtask

    task automatic t_overflow64;
        run("R6 unsigned add", 3'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0,
            1'b0, 64'd0, 8'hC1, 64'h0, 2'b01);
        run("R7 signed add", 3'd0, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd0,
            1'b0, 64'd0, 8'hC1, 64'h8000_0000_0000_0000, 2'b10);
        run("R7 signed disabled", 3'd0, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd0,
            1'b0, 64'd0, 8'h41, 64'h8000_0000_0000_0000, 2'b00);
    endtask

    task automatic t_narrow;
        run("R11 R3 sub8 borrow", 3'd1, 2'd0, 64'hFFFF_FF10, 64'h20, 64'd0,
            1'b0, 64'd0, 8'hC1, 64'hF0, 2'b01);
        run("R7 both causes", 3'd0, 2'd0, 64'h80, 64'h80, 64'd0,
            1'b0, 64'd0, 8'hC1, 64'h00, 2'b11);
    endtask

    task automatic t_mul;
        run("R8 mul32 signed", 3'd2, 2'd2, 64'd65537, 64'd32769, 64'd0,
            1'b0, 64'd0, 8'hC1, 64'h8001_8001, 2'b10);
        run("R8 mul64 high half", 3'd2, 2'd3, 64'h1_0000_0000, 64'h1_0000_0000, 64'd0,
            1'b0, 64'd0, 8'hC1, 64'h0, 2'b11);
        run("R8 mul64 minus one squared", 3'd2, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF,
            64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 64'd0, 8'hC1, 64'h1, 2'b01);
    endtask

    task automatic t_madd;
        run("R9 fused madd", 3'd3, 2'd2, 64'd65537, 64'd32769, 64'hFFFE_7960,
            1'b0, 64'd0, 8'h81, 64'h7FFF_F961, 2'b00);
    endtask

    task automatic t_shift;
        run("R10 shl16 sign", 3'd4, 2'd1, 64'h4001, 64'd1, 64'd0,
            1'b0, 64'd0, 8'hC1, 64'h8002, 2'b10);
        run("R10 shl16 count wraps", 3'd4, 2'd1, 64'h8001, 64'd17, 64'd0,
            1'b0, 64'd0, 8'hC1, 64'h0002, 2'b11);
    endtask

    task automatic t_masked;
        run("R4 R5 fallback src_a", 3'd0, 2'd2, 64'h1234_5678_9ABC_DEF0, 64'h7000_0000,
            64'd0, 1'b0, 64'hFFFF, 8'hC0, 64'h9ABC_DEF0, 2'b00);
        run("R4 explicit fallback", 3'd0, 2'd1, 64'h7FFF, 64'h7FFF, 64'd0,
            1'b1, 64'hFFFF_0000_0000_1111, 8'hC0, 64'h1111, 2'b00);
    endtask

    task automatic t_reserved;
        run("R12 reserved op", 3'd5, 2'd3, 64'd3, 64'd4, 64'd0,
            1'b0, 64'd0, 8'hC1, 64'h0, 2'b00);
    endtask

    task automatic t_idle;
        run("R1 issue", 3'd0, 2'd0, 64'hFF, 64'h01, 64'd0, 1'b0, 64'd0, 8'hC1, 64'h00, 2'b01);
        @(negedge clk);
        check("R1 idle", 1'b0, 64'h00, 2'b00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_overflow64();
        t_narrow();
        t_mul();
        t_madd();
        t_shift();
        t_masked();
        t_reserved();
        t_idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule